// File: doc/BRIEF.md
# Repeated-Subtraction Integer Divider

This block divides one unsigned integer by another by subtracting the divisor from a running accumulator once per clock and counting how many subtractions fit. When the accumulator falls below the divisor, the count is the quotient and what is left in the accumulator is the remainder. The number of cycles grows with the quotient, so the block fits places where area matters and speed does not.

A parameter `FRAC` appends that many zero bits below the dividend before the division starts. The quotient then carries `FRAC` fraction bits, with the binary point between bit `FRAC` and bit `FRAC-1`. The remainder uses the same scaling. Each extra fraction bit roughly doubles the run time. A request is made with a one-cycle `start` while the block is idle. `busy` covers the run, and a one-cycle `done` marks valid results, which then hold until the next accepted start. A zero divisor ends the run at once with an error flag.

Top module: `rep_sub_divider`

## Requirements
- R1: After reset, `busy`, `done` and `divErr` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is 0 is accepted. `busy` is 1 from the next cycle on, and the operands are captured at that edge.
- R3: For a nonzero divisor, the results satisfy `quotient = (dividend * 2^FRAC) / divisor` and `remainder = (dividend * 2^FRAC) mod divisor`, both unsigned and `WIDTH+FRAC` bits wide.
- R4: For a nonzero divisor, the edge that samples `start` is edge 0. `done` is then first high after edge Q+1, where Q is the expected quotient, and `busy` is 1 after edges 0 through Q.
- R5: `done` is high for exactly one cycle and `busy` is 0 while it is high. `quotient`, `remainder` and `divErr` stay unchanged from the `done` cycle until the next accepted start.
- R6: With a divisor of 0, `done` is high after edge 1 and `divErr` is 1. `quotient` is then all ones and `remainder` holds `dividend * 2^FRAC`.
- R7: A `start` that is high while `busy` is 1 is ignored. The results and the `done` timing are those of the running operation.
- R8: The boundary cases are exact. A dividend smaller than the divisor gives quotient 0, the remainder is the scaled dividend, and `done` comes after edge 1 when `FRAC` is 0. A dividend equal to the divisor gives quotient `2^FRAC` and remainder 0. A divisor of 1 gives quotient `dividend * 2^FRAC` and remainder 0.
- R9: `divErr` is cleared by the next accepted start and stays 0 for any run with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | WIDTH | Unsigned dividend, captured on an accepted start |
| divisor | input | WIDTH | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| divErr | output | 1 | Last run had a zero divisor |
| quotient | output | WIDTH+FRAC | Quotient, FRAC fraction bits |
| remainder | output | WIDTH+FRAC | Remainder, same scaling as the scaled dividend |

## Verification
The bench first computes the expected quotient Q in its own functions. It then counts clock edges from the one that samples `start`, and requires `done` after edge Q+1, or after edge 1 for a zero divisor. `busy` must be high after edge 0. Every output is sampled on the falling edge after the edge that changes it. One cycle after `done`, the bench checks that `done` has dropped and that the results have held. Two instances run side by side, one with fraction bits and one without, so the binary-point scaling and the integer timing are both checked. A start pulse is also injected two cycles into a run to show that it changes neither the results nor the latency.

// File: rtl/rep_sub_div_pkg.sv
package rep_sub_div_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture operands, clear count
    logic step;        // subtract divisor, count one
    logic finishZero;  // zero divisor: force count to all ones
  } dpCtrlT;

  // Status from datapath to control
  typedef struct packed {
    logic accLtDiv;    // accumulator below divisor
    logic divZero;     // captured divisor is zero
  } dpStatT;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ctrlStateT;

endpackage

// File: rtl/rep_sub_div_datapath.sv
module rep_sub_div_datapath
  import rep_sub_div_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int FRAC  = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtrlT                  ctrl,
  input  logic [WIDTH-1:0]        dividend,
  input  logic [WIDTH-1:0]        divisor,
  output dpStatT                  stat,
  output logic [WIDTH+FRAC-1:0]   quotient,
  output logic [WIDTH+FRAC-1:0]   remainder
);

  localparam int AW = WIDTH + FRAC;

  logic [AW-1:0]    accReg;
  logic [AW-1:0]    cntReg;
  logic [WIDTH-1:0] divReg;
  logic [AW-1:0]    loadVal;
  logic [AW-1:0]    divWide;

  // Scaled dividend: FRAC zero bits appended below the LSB
  generate
    if (FRAC == 0) begin : g_noFrac
      assign loadVal = dividend;
    end else begin : g_frac
      assign loadVal = {dividend, {FRAC{1'b0}}};
    end
  endgenerate

  assign divWide = AW'(divReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      cntReg <= '0;
      divReg <= '0;
    end else if (ctrl.load) begin
      accReg <= loadVal;
      cntReg <= '0;
      divReg <= divisor;
    end else if (ctrl.finishZero) begin
      cntReg <= '1;
    end else if (ctrl.step) begin
      accReg <= accReg - divWide;
      cntReg <= cntReg + AW'(1);
    end
  end

  assign stat.accLtDiv = (accReg < divWide);
  assign stat.divZero  = (divReg == '0);
  assign quotient      = cntReg;
  assign remainder     = accReg;

  // Each step must shrink the accumulator and grow the count by one
  AST_ACC_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> (accReg < $past(accReg)));  // R3
  AST_CNT_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.step |=> (cntReg == $past(cntReg) + AW'(1)));  // R3
  // With no strobe, results hold
  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load || ctrl.step || ctrl.finishZero) |=> ($stable(accReg) && $stable(cntReg)));  // R5
  // Strobes are mutually exclusive
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.load, ctrl.step, ctrl.finishZero}));  // R2

endmodule

// File: rtl/rep_sub_div_control.sv
module rep_sub_div_control
  import rep_sub_div_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  dpStatT stat,
  output dpCtrlT ctrl,
  output logic   busy,
  output logic   done,
  output logic   divErr
);

  ctrlStateT state;
  ctrlStateT stateNext;
  logic      finishNorm;

  always_comb begin
    ctrl            = '0;
    finishNorm      = 1'b0;
    stateNext       = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        if (stat.divZero) begin
          ctrl.finishZero = 1'b1;
          stateNext       = ST_IDLE;
        end else if (stat.accLtDiv) begin
          finishNorm = 1'b1;
          stateNext  = ST_IDLE;
        end else begin
          ctrl.step = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      divErr <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctrl.finishZero || finishNorm;
      if (ctrl.load) begin
        divErr <= 1'b0;
      end else if (ctrl.finishZero) begin
        divErr <= 1'b1;
      end
    end
  end

  assign busy = (state == ST_RUN);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R5
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);  // R2
  AST_ZERO_DIV_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stat.divZero) |=> (done && divErr && !busy));  // R6
  AST_ERR_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stat.divZero) |=> !divErr);  // R9

endmodule

// File: rtl/rep_sub_divider.sv
module rep_sub_divider
  import rep_sub_div_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int FRAC  = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [WIDTH-1:0]      dividend,
  input  logic [WIDTH-1:0]      divisor,
  output logic                  busy,
  output logic                  done,
  output logic                  divErr,
  output logic [WIDTH+FRAC-1:0] quotient,
  output logic [WIDTH+FRAC-1:0] remainder
);

  dpCtrlT dpCtrl;
  dpStatT dpStat;

  rep_sub_div_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .stat   (dpStat),
    .ctrl   (dpCtrl),
    .busy   (busy),
    .done   (done),
    .divErr (divErr)
  );

  rep_sub_div_datapath #(
    .WIDTH (WIDTH),
    .FRAC  (FRAC)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (dpCtrl),
    .dividend  (dividend),
    .divisor   (divisor),
    .stat      (dpStat),
    .quotient  (quotient),
    .remainder (remainder)
  );

  // Results hold while idle and not restarted
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(divErr)));  // R5

endmodule

// File: tb/rep_sub_divider_bench.sv
module rep_sub_divider_bench;

  localparam int W  = 12;
  localparam int FR = 3;
  localparam int AWF = W + FR;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  // Fraction instance
  logic startF = 1'b0;
  logic [W-1:0] aF = '0, bF = '0;
  logic busyF, doneF, errF;
  logic [AWF-1:0] qF, rF;

  // Integer instance
  logic startI = 1'b0;
  logic [W-1:0] aI = '0, bI = '0;
  logic busyI, doneI, errI;
  logic [W-1:0] qI, rI;

  rep_sub_divider #(.WIDTH(W), .FRAC(FR)) u_rep_sub_divider (
    .clk(clk), .rstN(rstN), .start(startF), .dividend(aF), .divisor(bF),
    .busy(busyF), .done(doneF), .divErr(errF), .quotient(qF), .remainder(rF));

  rep_sub_divider #(.WIDTH(W), .FRAC(0)) u_rep_sub_divider_int (
    .clk(clk), .rstN(rstN), .start(startI), .dividend(aI), .divisor(bI),
    .busy(busyI), .done(doneI), .divErr(errI), .quotient(qI), .remainder(rI));

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expQ(input int fr, input longint a, input longint b);
    longint n = a << fr;
    if (b == 0) return (longint'(1) << (W + fr)) - 1;
    return n / b;
  endfunction

  function automatic longint expR(input int fr, input longint a, input longint b);
    longint n = a << fr;
    if (b == 0) return n;
    return n % b;
  endfunction

  logic useInt = 1'b0;
  wire  obsBusy = useInt ? busyI : busyF;
  wire  obsDone = useInt ? doneI : doneF;
  wire  obsErr  = useInt ? errI  : errF;
  wire [AWF-1:0] obsQ = useInt ? AWF'(qI) : qF;
  wire [AWF-1:0] obsR = useInt ? AWF'(rI) : rF;

  task automatic setStart(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    if (useInt) begin startI = v; aI = a; bI = b; end
    else begin startF = v; aF = a; bF = b; end
  endtask

  // One operation; inject=1 pulses start again two cycles into the run (R7)
  task automatic runOne(input bit intSel, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit inject, input string tag);
    int fr = intSel ? 0 : FR;
    longint eq = expQ(fr, a, b);
    longint er = expR(fr, a, b);
    longint eLat = (b == 0) ? 1 : eq + 1;
    int k;
    longint qHold, rHold;
    @(negedge clk);
    useInt = intSel;
    setStart(1'b1, a, b);
    @(posedge clk);
    @(negedge clk);
    setStart(1'b0, ~a, b + 1);
    k = 0;
    check({tag, " R2 busy after start"}, obsBusy, 1);
    while (!obsDone && k < 40000) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (inject && k == 2) setStart(1'b1, a ^ 12'h5a5, 12'd1);
      if (inject && k == 3) setStart(1'b0, a, b);
    end
    setStart(1'b0, a, b);
    check({tag, " R4 done latency"}, k, eLat);
    check({tag, " R3 quotient"}, obsQ, eq);
    check({tag, " R3 remainder"}, obsR, er);
    check({tag, " R6/R9 error flag"}, obsErr, (b == 0) ? 1 : 0);
    check({tag, " R5 not busy at done"}, obsBusy, 0);
    qHold = obsQ;
    rHold = obsR;
    @(negedge clk);
    check({tag, " R5 done one cycle"}, obsDone, 0);
    check({tag, " R5 quotient held"}, obsQ, qHold);
    check({tag, " R5 remainder held"}, obsR, rHold);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    @(negedge clk);
    check("R1 busy reset", busyF, 0);
    check("R1 done reset", doneF, 0);
    check("R1 err reset", errF, 0);
    check("R1 quotient reset", qF, 0);
    check("R1 remainder reset", rF, 0);
    check("R1 int quotient reset", qI, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Directed corners, integer instance
    runOne(1, 12'd5, 12'd9, 0, "r8_lt int");
    runOne(1, 12'd77, 12'd77, 0, "r8_eq int");
    runOne(1, 12'd300, 12'd1, 0, "r8_one int");
    runOne(1, 12'd100, 12'd0, 0, "r6_zero int");
    runOne(1, 12'd50, 12'd7, 0, "r9_after_err int");
    runOne(1, 12'd4095, 12'd1, 0, "r8_max int");
    runOne(1, 12'd90, 12'd4, 1, "r7_inject int");

    // Directed corners, fraction instance
    runOne(0, 12'd5, 12'd9, 0, "r8_lt frac");
    runOne(0, 12'd77, 12'd77, 0, "r8_eq frac");
    runOne(0, 12'd200, 12'd1, 0, "r8_one frac");
    runOne(0, 12'd3, 12'd0, 0, "r6_zero frac");
    runOne(0, 12'd10, 12'd4, 0, "r3_point frac");
    runOne(0, 12'd4095, 12'd1, 0, "r8_max frac");
    runOne(0, 12'd123, 12'd11, 1, "r7_inject frac");

    // Constrained random: quotient kept small
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] a, b;
      int lo;
      bit sel;
      sel = ($urandom % 2) == 1;
      a = W'($urandom);
      lo = ((int'(a) << (sel ? 0 : FR)) >> 6) + 1;
      if (lo > 4095) lo = 4095;
      b = W'(lo + ($urandom % (4096 - lo)));
      runOne(sel, a, b, ($urandom % 4) == 0, "r3_rand");
    end

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule